// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns a decoded operand specifier into a memory address. It takes the two-bit mode field, the three-bit register/memory code, the word-size bit, a displacement and the current base, index and segment register values. From these it forms a 16-bit offset, picks a segment and produces the 20-bit physical address.

The block sits between instruction decode and the bus interface. A request strobe marks the cycle in which the specifier is valid. One clock later the block shows the registered result. A separate flag says when the specifier names a register operand instead of memory. In that case no address is produced, and the block reports which register was named.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is held and just after it, `addr_valid` and `reg_operand` are 0, `offset`, `seg_value` and `phys_addr` are 0, and `seg_code` is 2'b11 (data segment).
- R2: A request with `mode` other than 2'b11 raises `addr_valid` for exactly one cycle, on the clock edge after the request. The results appear on that same edge.
- R3: With `mode`=2'b00, `rm` picks the offset as 000:BX+SI, 001:BX+DI, 010:BP+SI, 011:BP+DI, 100:SI, 101:DI, 111:BX.
- R4: With `mode`=2'b01, the low byte of `disp` is sign-extended to 16 bits and added to the `rm` base/index sum. For `rm`=110 that sum is BP.
- R5: With `mode`=2'b10, the full 16-bit `disp` is added to the `rm` base/index sum. For `rm`=110 that sum is BP.
- R6: With `mode`=2'b00 and `rm`=110, the offset is `disp` itself, and BP is not used.
- R7: The offset sum wraps modulo 65536.
- R8: With no override, a reference whose base is BP uses the stack segment (code 2'b10). That covers `rm` 010 and 011 in any memory mode, and `rm` 110 in modes 01 and 10. Every other reference uses the data segment (code 2'b11).
- R9: When `ovr_en` is 1, `seg_code` equals `ovr_sel`, using the codes ES=00, CS=01, SS=10, DS=11. `seg_value` is the register that the code names.
- R10: `phys_addr` equals `seg_value` shifted left four bits plus the zero-extended `offset`, taken modulo 2^20.
- R11: A request with `mode`=2'b11 sets `reg_operand` to 1 and loads `reg_id` with {`wide`, `rm`}. It leaves `addr_valid` at 0, and `offset`, `seg_code`, `seg_value` and `phys_addr` keep their previous values.
- R12: In a cycle with no request, `addr_valid` goes to 0 and every other output keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Specifier valid this cycle |
| mode | input | 2 | Addressing mode field |
| rm | input | 3 | Register/memory code |
| wide | input | 1 | Word-size bit |
| disp | input | 16 | Displacement or direct address |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| seg_es | input | 16 | Extra segment value |
| seg_cs | input | 16 | Code segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_ds | input | 16 | Data segment value |
| ovr_en | input | 1 | Segment override requested |
| ovr_sel | input | 2 | Override segment code |
| addr_valid | output | 1 | Memory address result valid (one cycle) |
| reg_operand | output | 1 | Last request named a register |
| reg_id | output | 4 | {wide, rm} of last register request |
| offset | output | 16 | Effective offset |
| seg_code | output | 2 | Selected segment code |
| seg_value | output | 16 | Selected segment value |
| phys_addr | output | 20 | Physical address |

## Verification
The bench aims at three main corner cases.
- Mode 00 with `rm`=110 must return the direct address. A design that reads BP there gives a wrong offset, and it may also switch to the stack segment.
- An 8-bit displacement of 0x80 or above must subtract from the base. A design that zero-extends it gives an offset 256 too high.
- Offsets and physical addresses near 0xFFFF and 0xFFFFF must wrap. A design that carries out of these widths, or forms the address before wrapping the offset, gives the wrong address.

The bench also checks that register-mode and idle cycles leave the address outputs frozen. A design that updates the address registers on those cycles shows new values there.

// File: rtl/ea_pkg.sv
// Shared widths, segment codes and helpers for the effective address generator.
// Assumes a 16-bit offset space and a four-bit segment shift.
package ea_pkg;
    localparam int OFF_W     = 16;
    localparam int SEG_SHIFT = 4;
    localparam int PA_W      = OFF_W + SEG_SHIFT;

    typedef enum logic [1:0] {
        SEG_EXTRA = 2'b00,
        SEG_CODE  = 2'b01,
        SEG_STACK = 2'b10,
        SEG_DATA  = 2'b11
    } seg_code_t;

    localparam logic [1:0] MODE_NODISP = 2'b00;
    localparam logic [1:0] MODE_DISP8  = 2'b01;
    localparam logic [1:0] MODE_DISP16 = 2'b10;
    localparam logic [1:0] MODE_REG    = 2'b11;
endpackage

// File: rtl/ea_offset_calc.sv
// Combinational offset former.
// Adds the base/index pair that rm picks to the displacement that mode picks.
// Handles the direct-address case. Sums wrap at the offset width.
// Assumes mode is not the register mode whenever the result is used.
module ea_offset_calc #(
    parameter int W = 16
) (
    input  logic [1:0]   mode,
    input  logic [2:0]   rm,
    input  logic [W-1:0] disp,
    input  logic [W-1:0] reg_bx,
    input  logic [W-1:0] reg_bp,
    input  logic [W-1:0] reg_si,
    input  logic [W-1:0] reg_di,
    output logic [W-1:0] off_out,
    output logic         bp_based
);
    import ea_pkg::*;

    logic [W-1:0] base_sum;
    logic [W-1:0] disp_ext;
    logic         direct;

    // Pick the base/index sum that the rm code names
    always_comb begin
        case (rm)
            3'b000:  base_sum = reg_bx + reg_si;
            3'b001:  base_sum = reg_bx + reg_di;
            3'b010:  base_sum = reg_bp + reg_si;
            3'b011:  base_sum = reg_bp + reg_di;
            3'b100:  base_sum = reg_si;
            3'b101:  base_sum = reg_di;
            3'b110:  base_sum = reg_bp;
            default: base_sum = reg_bx;
        endcase
    end

    // Spot the direct-address form (no displacement mode, rm 110)
    always_comb direct = (mode == MODE_NODISP) && (rm == 3'b110);

    // Select and widen the displacement for the current mode
    always_comb begin
        case (mode)
            MODE_DISP8:  disp_ext = {{(W-8){disp[7]}}, disp[7:0]};
            MODE_DISP16: disp_ext = disp;
            default:     disp_ext = '0;
        endcase
    end

    // Form the final offset and flag a BP-based reference
    always_comb begin
        off_out  = direct ? disp : (base_sum + disp_ext);
        bp_based = !direct && ((rm == 3'b010) || (rm == 3'b011) || (rm == 3'b110));
    end
endmodule

// File: rtl/ea_seg_select.sv
// Combinational segment chooser.
// The default is stack for a BP-based reference and data for any other.
// An override replaces the default with any of the four codes.
// Also returns the value of the chosen segment register.
module ea_seg_select #(
    parameter int W = 16
) (
    input  logic         bp_based,
    input  logic         ovr_en,
    input  logic [1:0]   ovr_sel,
    input  logic [W-1:0] seg_es,
    input  logic [W-1:0] seg_cs,
    input  logic [W-1:0] seg_ss,
    input  logic [W-1:0] seg_ds,
    output logic [1:0]   code_out,
    output logic [W-1:0] value_out
);
    import ea_pkg::*;

    logic [W-1:0] seg_bank [4];

    // Arrange the segment registers by their code
    always_comb begin
        seg_bank[SEG_EXTRA] = seg_es;
        seg_bank[SEG_CODE]  = seg_cs;
        seg_bank[SEG_STACK] = seg_ss;
        seg_bank[SEG_DATA]  = seg_ds;
    end

    // Resolve the code from override or default, then read the bank
    always_comb begin
        if (ovr_en) code_out = ovr_sel;
        else        code_out = bp_based ? SEG_STACK : SEG_DATA;
        value_out = seg_bank[code_out];
    end
endmodule

// File: rtl/ea_phys_adder.sv
// Combinational physical address adder.
// Shifts the segment left by SHIFT bits and adds the zero-extended offset.
// The sum wraps at W+SHIFT bits.
module ea_phys_adder #(
    parameter int W     = 16,
    parameter int SHIFT = 4
) (
    input  logic [W-1:0]       seg_val,
    input  logic [W-1:0]       off_val,
    output logic [W+SHIFT-1:0] phys
);
    localparam int PW = W + SHIFT;

    // Add the shifted segment and the widened offset
    always_comb phys = {seg_val, {SHIFT{1'b0}}} + PW'(off_val);
endmodule

// File: rtl/seg_addr_gen.sv
// Segmented effective address generator (top).
// Registers the offset, segment and physical address one cycle after a request.
// A register-mode request only updates the register flag and id.
// With no request, everything holds except the valid pulse.
module seg_addr_gen #(
    parameter int OFF_W     = ea_pkg::OFF_W,
    parameter int SEG_SHIFT = ea_pkg::SEG_SHIFT
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req,
    input  logic [1:0]                 mode,
    input  logic [2:0]                 rm,
    input  logic                       wide,
    input  logic [OFF_W-1:0]           disp,
    input  logic [OFF_W-1:0]           reg_bx,
    input  logic [OFF_W-1:0]           reg_bp,
    input  logic [OFF_W-1:0]           reg_si,
    input  logic [OFF_W-1:0]           reg_di,
    input  logic [OFF_W-1:0]           seg_es,
    input  logic [OFF_W-1:0]           seg_cs,
    input  logic [OFF_W-1:0]           seg_ss,
    input  logic [OFF_W-1:0]           seg_ds,
    input  logic                       ovr_en,
    input  logic [1:0]                 ovr_sel,
    output logic                       addr_valid,
    output logic                       reg_operand,
    output logic [3:0]                 reg_id,
    output logic [OFF_W-1:0]           offset,
    output logic [1:0]                 seg_code,
    output logic [OFF_W-1:0]           seg_value,
    output logic [OFF_W+SEG_SHIFT-1:0] phys_addr
);
    import ea_pkg::*;

    localparam int PW = OFF_W + SEG_SHIFT;

    logic [OFF_W-1:0] off_c;
    logic             bp_c;
    logic [1:0]       code_c;
    logic [OFF_W-1:0] segv_c;
    logic [PW-1:0]    phys_c;
    logic             is_reg_c;
    logic             mem_req;

    ea_offset_calc #(.W(OFF_W)) u_off (
        .mode(mode), .rm(rm), .disp(disp),
        .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
        .off_out(off_c), .bp_based(bp_c)
    );

    ea_seg_select #(.W(OFF_W)) u_seg (
        .bp_based(bp_c), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
        .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
        .code_out(code_c), .value_out(segv_c)
    );

    ea_phys_adder #(.W(OFF_W), .SHIFT(SEG_SHIFT)) u_pa (
        .seg_val(segv_c), .off_val(off_c), .phys(phys_c)
    );

    // Classify the incoming request
    always_comb begin
        is_reg_c = (mode == MODE_REG);
        mem_req  = req && !is_reg_c;
    end

    // Valid pulse and register-operand flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_valid  <= 1'b0;
            reg_operand <= 1'b0;
            reg_id      <= '0;
        end else begin
            addr_valid <= mem_req;
            if (req) reg_operand <= is_reg_c;
            if (req && is_reg_c) reg_id <= {wide, rm};
        end
    end

    // Address result registers, loaded only by memory requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset    <= '0;
            seg_code  <= SEG_DATA;
            seg_value <= '0;
            phys_addr <= '0;
        end else if (mem_req) begin
            offset    <= off_c;
            seg_code  <= code_c;
            seg_value <= segv_c;
            phys_addr <= phys_c;
        end
    end
endmodule

// File: rtl/seg_addr_gen_chk.sv
// Assertion checker for seg_addr_gen, attached by bind.
// Relates requests to the registered results one cycle later.
module seg_addr_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req,
    input logic [1:0]  mode,
    input logic [2:0]  rm,
    input logic        ovr_en,
    input logic [1:0]  ovr_sel,
    input logic [15:0] seg_es,
    input logic        addr_valid,
    input logic        reg_operand,
    input logic [15:0] offset,
    input logic [1:0]  seg_code,
    input logic [15:0] seg_value,
    input logic [19:0] phys_addr
);
    assert_valid_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode != 2'b11) |=> addr_valid);

    assert_valid_needs_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !addr_valid && $stable(phys_addr) && $stable(offset));

    assert_reg_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode == 2'b11) |=> !addr_valid && reg_operand && $stable(phys_addr) && $stable(seg_code));

    assert_override_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode != 2'b11 && ovr_en) |=> seg_code == $past(ovr_sel));

    assert_es_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode != 2'b11 && ovr_en && ovr_sel == 2'b00) |=> seg_value == $past(seg_es));

    assert_bp_stack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && mode != 2'b11 && !ovr_en && (rm == 3'b010 || rm == 3'b011 || (rm == 3'b110 && mode != 2'b00)))
        |=> seg_code == 2'b10);

    assert_phys_sum_R10: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |-> phys_addr == ({seg_value, 4'b0000} + {4'b0000, offset}));

    assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_valid && reg_operand));
endmodule

bind seg_addr_gen seg_addr_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .rm(rm),
    .ovr_en(ovr_en), .ovr_sel(ovr_sel), .seg_es(seg_es),
    .addr_valid(addr_valid), .reg_operand(reg_operand), .offset(offset),
    .seg_code(seg_code), .seg_value(seg_value), .phys_addr(phys_addr)
);

// File: tb/sim_seg_addr_gen.sv
// Bench for seg_addr_gen: directed corners plus seeded random requests.
module sim_seg_addr_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic [1:0] mode = '0;
    logic [2:0] rm = '0;
    logic wide = 1'b0;
    logic [15:0] disp = '0, reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0;
    logic [15:0] seg_es = '0, seg_cs = '0, seg_ss = '0, seg_ds = '0;
    logic ovr_en = 1'b0;
    logic [1:0] ovr_sel = '0;
    logic addr_valid, reg_operand;
    logic [3:0] reg_id;
    logic [15:0] offset, seg_value;
    logic [1:0] seg_code;
    logic [19:0] phys_addr;

    int n_chk = 0;
    int n_fail = 0;

    // Expected held state
    logic [15:0] e_off = '0, e_segv = '0;
    logic [1:0]  e_code = 2'b11;
    logic [19:0] e_pa = '0;
    logic        e_isreg = 1'b0;
    logic [3:0]  e_rid = '0;

    always #5 clk = ~clk;

    seg_addr_gen u0 (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_off(input logic [1:0] md, input logic [2:0] r, input logic [15:0] d,
                                            input logic [15:0] bx, input logic [15:0] bp,
                                            input logic [15:0] si, input logic [15:0] di);
        logic [15:0] b;
        logic [15:0] dx;
        if (md == 2'b00 && r == 3'b110) return d;
        case (r)
            3'd0: b = bx + si;
            3'd1: b = bx + di;
            3'd2: b = bp + si;
            3'd3: b = bp + di;
            3'd4: b = si;
            3'd5: b = di;
            3'd6: b = bp;
            default: b = bx;
        endcase
        if (md == 2'b01) dx = {{8{d[7]}}, d[7:0]};
        else if (md == 2'b10) dx = d;
        else dx = 16'h0;
        return b + dx;
    endfunction

    function automatic logic [1:0] ref_code(input logic [1:0] md, input logic [2:0] r,
                                            input logic oe, input logic [1:0] os);
        if (oe) return os;
        if (r == 3'd2 || r == 3'd3 || (r == 3'd6 && md != 2'b00)) return 2'b10;
        return 2'b11;
    endfunction

    // Apply one cycle of stimulus, then check outputs after the edge
    task automatic step(input logic rq, input string tag);
        logic [15:0] sv;
        logic        exp_v;
        req = rq;
        @(posedge clk);
        exp_v = rq && mode != 2'b11;
        if (rq) begin
            if (mode == 2'b11) begin
                e_isreg = 1'b1;
                e_rid = {wide, rm};
            end else begin
                e_isreg = 1'b0;
                e_off = ref_off(mode, rm, disp, reg_bx, reg_bp, reg_si, reg_di);
                e_code = ref_code(mode, rm, ovr_en, ovr_sel);
                case (e_code)
                    2'b00: sv = seg_es;
                    2'b01: sv = seg_cs;
                    2'b10: sv = seg_ss;
                    default: sv = seg_ds;
                endcase
                e_segv = sv;
                e_pa = {sv, 4'h0} + {4'h0, e_off};
            end
        end
        @(negedge clk);
        check({tag, " R2/R12 valid"}, 32'(addr_valid), 32'(exp_v));
        check({tag, " R11 reg_operand"}, 32'(reg_operand), 32'(e_isreg));
        check({tag, " R11 reg_id"}, 32'(reg_id), 32'(e_rid));
        check({tag, " R3/R7 offset"}, 32'(offset), 32'(e_off));
        check({tag, " R8/R9 seg_code"}, 32'(seg_code), 32'(e_code));
        check({tag, " R9 seg_value"}, 32'(seg_value), 32'(e_segv));
        check({tag, " R10 phys"}, 32'(phys_addr), 32'(e_pa));
        req = 1'b0;
    endtask

    task automatic setop(input logic [1:0] md, input logic [2:0] r, input logic [15:0] d,
                         input logic oe, input logic [1:0] os);
        mode = md; rm = r; disp = d; ovr_en = oe; ovr_sel = os;
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 valid", 32'(addr_valid), 0);
        check("R1 reg_operand", 32'(reg_operand), 0);
        check("R1 phys", 32'(phys_addr), 0);
        check("R1 offset", 32'(offset), 0);
        check("R1 seg_code", 32'(seg_code), 32'h3);
        rst_n = 1'b1;

        reg_bx = 16'h1000; reg_bp = 16'h2000; reg_si = 16'h0030; reg_di = 16'h0004;
        seg_es = 16'h0400; seg_cs = 16'h0100; seg_ss = 16'h0300; seg_ds = 16'h0200;

        // R3: every mode 00 combination
        for (int r = 0; r < 8; r++) begin
            setop(2'b00, 3'(r), 16'h1234, 1'b0, 2'b00);
            step(1'b1, "R3 table");
        end
        // R6: direct address, data segment
        setop(2'b00, 3'd6, 16'h1234, 1'b0, 2'b00);
        step(1'b1, "R6 direct");
        check("R6 direct offset", 32'(offset), 32'h1234);
        check("R6 direct phys", 32'(phys_addr), 32'h03234);
        // R4: negative byte displacement on BP
        setop(2'b01, 3'd6, 16'h00F0, 1'b0, 2'b00);
        step(1'b1, "R4 disp8 neg");
        check("R4 offset", 32'(offset), 32'h1FF0);
        check("R8 bp stack", 32'(seg_code), 32'h2);
        // R5: 16-bit displacement
        setop(2'b10, 3'd7, 16'h1234, 1'b0, 2'b00);
        step(1'b1, "R5 disp16");
        check("R5 phys", 32'(phys_addr), 32'h04234);
        // R7 / R10 wrap
        reg_bx = 16'hFFF0; reg_si = 16'h0020;
        setop(2'b10, 3'd0, 16'h0001, 1'b0, 2'b00);
        step(1'b1, "R7 wrap");
        check("R7 wrapped offset", 32'(offset), 32'h0011);
        seg_cs = 16'hFFFF;
        setop(2'b00, 3'd7, 16'h0000, 1'b1, 2'b01);
        step(1'b1, "R10 wrap");
        check("R10 wrapped phys", 32'(phys_addr), 32'h0FFE0);
        // R9: every override code on a BP reference
        for (int s = 0; s < 4; s++) begin
            setop(2'b01, 3'd2, 16'h0001, 1'b1, 2'(s));
            step(1'b1, "R9 override");
        end
        // R11: register mode holds address
        wide = 1'b1;
        setop(2'b11, 3'd5, 16'hBEEF, 1'b0, 2'b00);
        step(1'b1, "R11 regmode");
        // R12: idle with changed inputs
        setop(2'b10, 3'd1, 16'h4444, 1'b1, 2'b10);
        step(1'b0, "R12 idle");

        // Random mix
        for (int i = 0; i < 600; i++) begin
            reg_bx = 16'($urandom); reg_bp = 16'($urandom);
            reg_si = 16'($urandom); reg_di = 16'($urandom);
            seg_es = 16'($urandom); seg_cs = 16'($urandom);
            seg_ss = 16'($urandom); seg_ds = 16'($urandom);
            wide = 1'($urandom);
            setop(2'($urandom), 3'($urandom), 16'($urandom), ($urandom % 4) == 0, 2'($urandom));
            step(($urandom % 5) != 0, "rand");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule